// File: doc/BRIEF.md
# Polled Port Command Controller

This block sits on the device side of a small host register port. It runs single-byte commands through a busy/command-ready handshake. The host uses a 2-bit register bus, with a write enable and a combinational read-back, to reach four 8-bit registers: a received-byte register, a transmit-byte register, a status register and a command register. The host first polls the busy flag until it reads clear. It then loads the transmit byte and the command bits, in either order. It sets the command-ready bit last.

When command-ready is seen, the controller raises busy before it looks at the command. A write command presents the transmit byte to a sink with a strobe. The strobe is held until the sink answers ready. A read command raises a request until the source answers valid, then captures the byte it gets. Completion clears three flags in a fixed order, one per cycle: error first, then command-ready, then busy. The fall of busy tells the host that the operation is over.

If the command names no transfer, it ends with the error flag set. The same happens when the far side does not answer within a bounded number of cycles.

Top module: `port_cmd_ctrl`

## Requirements
- R1: After reset every register reads 0x00 and both `dev_valid_o` and `rd_req_o` are low.
- R2: Register map. Address 0 is the received byte, read-only. Address 1 is the transmit byte, read/write. Address 2 is status, read-only: bit0 busy, bit1 error, bit2 input-ready. Address 3 is command, read/write: bit0 write, bit1 command-ready, bit2 read. Unused bits read 0.
- R3: Busy goes high on the second rising edge after the host write that sets command-ready. It never goes high unless command-ready was already set.
- R4: A write command drives the transmit byte on `dev_data_o` with `dev_valid_o` high. The strobe and the byte are held until the edge that samples `dev_ready_i` high.
- R5: On success, error clears on the edge that accepts the handshake, command-ready clears one cycle later, and busy clears one cycle after that.
- R6: A command with command-ready set but neither write nor read set makes no transfer. It sets error, then clears command-ready, then clears busy.
- R7: While busy is high, host writes to the transmit and command registers are ignored. Status and all other registers stay readable.
- R8: If the handshake is still missing on the TIMEOUT-th edge (default 255) after the strobe appears, the strobe drops, error is set, and the command ends. An answer after TIMEOUT-1 waiting edges still succeeds.
- R9: A read command holds `rd_req_o` high until `dev_in_valid_i`. It then stores `dev_in_data_i` in the received-byte register and sets input-ready. Input-ready clears when the next command raises busy.
- R10: When write and read are both set, the write is performed and no read request is issued.
- R11: Loading the transmit byte before or after the write bit gives the same output byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| we_i | input | 1 | Register write enable |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational on addr_i |
| dev_data_o | output | 8 | Byte to the sink |
| dev_valid_o | output | 1 | Output strobe, held until ready |
| dev_ready_i | input | 1 | Sink accepts the byte |
| rd_req_o | output | 1 | Read request to the source |
| dev_in_data_i | input | 8 | Byte from the source |
| dev_in_valid_i | input | 1 | Source byte is valid |

## Verification
The timeout edge is the hardest case to reach from the ports, because it needs the sink to stay silent for exactly the right number of cycles. The bench models the sink with a programmable delay. It runs one write whose answer comes after TIMEOUT-1 waiting edges, which must succeed. It runs another with no answer at all, and counts the cycles the strobe stays high. The flag clearing order can only be seen if error was set beforehand. For that, an illegal command comes first, then a good write, and the status and command registers are read on each cycle of the wind-down. Writes landing while busy is high are sent while the sink holds back its ready.

// File: rtl/port_cmd_pkg.sv
package port_cmd_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_DIN  = 2'd0;
  localparam logic [ADDR_W-1:0] A_DOUT = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
  localparam logic [ADDR_W-1:0] A_CMD  = 2'd3;

  // status bits
  localparam int unsigned S_BUSY = 0;
  localparam int unsigned S_ERR  = 1;
  localparam int unsigned S_INRDY = 2;
  // command bits
  localparam int unsigned C_WR  = 0;
  localparam int unsigned C_RDY = 1;
  localparam int unsigned C_RD  = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECODE, ST_WR, ST_RD, ST_CLR_RDY, ST_CLR_BUSY
  } state_e;
endpackage

// File: rtl/port_cmd_regs.sv
module port_cmd_regs
  import port_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [REG_W-1:0]  data_out_o,
  output logic              busy_o,
  output logic              err_o,
  output logic              cmd_rdy_o,
  output logic              cmd_wr_o,
  output logic              cmd_rd_o,
  input  logic              set_busy_i,
  input  logic              clr_busy_i,
  input  logic              set_err_i,
  input  logic              clr_err_i,
  input  logic              clr_rdy_i,
  input  logic              cap_in_i,
  input  logic [REG_W-1:0]  in_byte_i
);
  logic [REG_W-1:0] data_in_q;
  logic             in_rdy_q;
  logic             host_we;

  assign host_we = we_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_out_o <= '0;
      data_in_q  <= '0;
      in_rdy_q   <= 1'b0;
      busy_o     <= 1'b0;
      err_o      <= 1'b0;
      cmd_rdy_o  <= 1'b0;
      cmd_wr_o   <= 1'b0;
      cmd_rd_o   <= 1'b0;
    end else begin
      if (host_we && addr_i == A_DOUT) data_out_o <= wdata_i;
      if (host_we && addr_i == A_CMD) begin
        cmd_wr_o  <= wdata_i[C_WR];
        cmd_rdy_o <= wdata_i[C_RDY];
        cmd_rd_o  <= wdata_i[C_RD];
      end else if (clr_rdy_i) begin
        cmd_rdy_o <= 1'b0;
      end
      if (set_busy_i) begin
        busy_o   <= 1'b1;
        in_rdy_q <= 1'b0;
      end else if (clr_busy_i) begin
        busy_o <= 1'b0;
      end
      if (set_err_i)      err_o <= 1'b1;
      else if (clr_err_i) err_o <= 1'b0;
      if (cap_in_i) begin
        data_in_q <= in_byte_i;
        in_rdy_q  <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_DIN:  rdata_o = data_in_q;
      A_DOUT: rdata_o = data_out_o;
      A_STAT: begin
        rdata_o[S_BUSY]  = busy_o;
        rdata_o[S_ERR]   = err_o;
        rdata_o[S_INRDY] = in_rdy_q;
      end
      A_CMD: begin
        rdata_o[C_WR]  = cmd_wr_o;
        rdata_o[C_RDY] = cmd_rdy_o;
        rdata_o[C_RD]  = cmd_rd_o;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/port_cmd_timer.sv
module port_cmd_timer #(
  parameter int unsigned LIMIT = 255,
  localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ack_i,
  output logic expire_o
);
  logic [CNT_W-1:0] cnt_q;

  // fires on the LIMIT-th enabled edge without an answer
  assign expire_o = en_i && !ack_i && (cnt_q == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || ack_i)    cnt_q <= '0;
    else if (!expire_o)         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/port_cmd_fsm.sv
module port_cmd_fsm
  import port_cmd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_rdy_i,
  input  logic cmd_wr_i,
  input  logic cmd_rd_i,
  input  logic dev_ready_i,
  input  logic dev_in_valid_i,
  input  logic expire_i,
  output logic wait_o,
  output logic ack_o,
  output logic dev_valid_o,
  output logic rd_req_o,
  output logic set_busy_o,
  output logic clr_busy_o,
  output logic set_err_o,
  output logic clr_err_o,
  output logic clr_rdy_o,
  output logic cap_in_o
);
  state_e state_q, state_d;

  assign dev_valid_o = (state_q == ST_WR);
  assign rd_req_o    = (state_q == ST_RD);
  assign wait_o      = dev_valid_o || rd_req_o;
  assign ack_o       = (dev_valid_o && dev_ready_i) || (rd_req_o && dev_in_valid_i);

  always_comb begin
    state_d    = state_q;
    set_busy_o = 1'b0;
    clr_busy_o = 1'b0;
    set_err_o  = 1'b0;
    clr_err_o  = 1'b0;
    clr_rdy_o  = 1'b0;
    cap_in_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (cmd_rdy_i) begin
        set_busy_o = 1'b1;
        state_d    = ST_DECODE;
      end
      ST_DECODE: begin
        if (cmd_wr_i)      state_d = ST_WR;
        else if (cmd_rd_i) state_d = ST_RD;
        else begin
          set_err_o = 1'b1;
          state_d   = ST_CLR_RDY;
        end
      end
      ST_WR, ST_RD: begin
        if (ack_o) begin
          clr_err_o = 1'b1;
          cap_in_o  = rd_req_o;
          state_d   = ST_CLR_RDY;
        end else if (expire_i) begin
          set_err_o = 1'b1;
          state_d   = ST_CLR_RDY;
        end
      end
      ST_CLR_RDY: begin
        clr_rdy_o = 1'b1;
        state_d   = ST_CLR_BUSY;
      end
      ST_CLR_BUSY: begin
        clr_busy_o = 1'b1;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/port_cmd_ctrl.sv
module port_cmd_ctrl
  import port_cmd_pkg::*;
#(
  parameter int unsigned TIMEOUT = 255
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [REG_W-1:0]  dev_data_o,
  output logic              dev_valid_o,
  input  logic              dev_ready_i,
  output logic              rd_req_o,
  input  logic [REG_W-1:0]  dev_in_data_i,
  input  logic              dev_in_valid_i
);
  logic busy, err, cmd_rdy, cmd_wr, cmd_rd;
  logic set_busy, clr_busy, set_err, clr_err, clr_rdy, cap_in;
  logic wait_act, ack, expire;
  logic [REG_W-1:0] data_out;

  assign dev_data_o = data_out;

  port_cmd_regs i_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .rdata_o,
    .data_out_o(data_out), .busy_o(busy), .err_o(err),
    .cmd_rdy_o(cmd_rdy), .cmd_wr_o(cmd_wr), .cmd_rd_o(cmd_rd),
    .set_busy_i(set_busy), .clr_busy_i(clr_busy),
    .set_err_i(set_err), .clr_err_i(clr_err), .clr_rdy_i(clr_rdy),
    .cap_in_i(cap_in), .in_byte_i(dev_in_data_i)
  );

  port_cmd_fsm i_fsm (
    .clk_i, .rst_ni,
    .cmd_rdy_i(cmd_rdy), .cmd_wr_i(cmd_wr), .cmd_rd_i(cmd_rd),
    .dev_ready_i, .dev_in_valid_i, .expire_i(expire),
    .wait_o(wait_act), .ack_o(ack), .dev_valid_o, .rd_req_o,
    .set_busy_o(set_busy), .clr_busy_o(clr_busy),
    .set_err_o(set_err), .clr_err_o(clr_err),
    .clr_rdy_o(clr_rdy), .cap_in_o(cap_in)
  );

  port_cmd_timer #(.LIMIT(TIMEOUT)) i_timer (
    .clk_i, .rst_ni, .en_i(wait_act), .ack_i(ack), .expire_o(expire)
  );
endmodule

// File: rtl/port_cmd_ctrl_chk.sv
module port_cmd_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] addr_i,
  input logic       we_i,
  input logic       busy,
  input logic       err,
  input logic       cmd_rdy,
  input logic [7:0] data_out,
  input logic [7:0] dev_data_o,
  input logic       dev_valid_o,
  input logic       dev_ready_i,
  input logic       rd_req_o
);
  a_r3_busy_needs_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(cmd_rdy));

  a_r5_rdy_drops_under_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cmd_rdy) |-> busy);

  a_r5_busy_drops_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> (!cmd_rdy && $past(cmd_rdy) == 1'b0));

  a_r4_strobe_under_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_valid_o || rd_req_o) |-> busy);

  a_r4_byte_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_valid_o && !dev_ready_i) |=> (!dev_valid_o || $stable(dev_data_o)));

  a_r8_drop_only_on_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_valid_o && !dev_ready_i) |=> (dev_valid_o || err));

  a_r7_dout_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && we_i && addr_i == 2'd1) |=> $stable(data_out));

  a_r10_one_direction: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dev_valid_o && rd_req_o));
endmodule

bind port_cmd_ctrl port_cmd_ctrl_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
  .busy(busy), .err(err), .cmd_rdy(cmd_rdy), .data_out(data_out),
  .dev_data_o(dev_data_o), .dev_valid_o(dev_valid_o),
  .dev_ready_i(dev_ready_i), .rd_req_o(rd_req_o)
);

// File: tb/test_port_cmd_ctrl.sv
module test_port_cmd_ctrl;
  localparam int TIMEOUT = 255;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] dev_data;
  logic       dev_valid;
  logic       dev_ready = 1'b0;
  logic       rd_req;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  port_cmd_ctrl #(.TIMEOUT(TIMEOUT)) i_port_cmd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .dev_data_o(dev_data), .dev_valid_o(dev_valid),
    .dev_ready_i(dev_ready), .rd_req_o(rd_req),
    .dev_in_data_i(in_data), .dev_in_valid_i(in_valid)
  );

  // data, order (1: write bit first), sink delay, both bits set
  typedef struct packed {
    logic [7:0] data;
    logic       order;
    logic [7:0] delay;
    logic       both;
  } vec_t;
  localparam vec_t VECS [5] = '{
    '{8'hA5, 1'b0, 8'd0,   1'b0},
    '{8'h3C, 1'b1, 8'd3,   1'b0},
    '{8'hFF, 1'b0, 8'd254, 1'b0},
    '{8'h00, 1'b1, 8'd1,   1'b1},
    '{8'h81, 1'b0, 8'd7,   1'b1}
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    @(negedge clk);
    for (int i = 0; i < 1000; i++) begin
      rd(2'd2, s);
      if (!s[0]) return;
      @(negedge clk);
    end
  endtask

  // sink: waits for strobe, holds ready off for dly edges
  task automatic sink(input int dly, output logic [7:0] got, output int seen);
    seen = 0;
    got = '0;
    for (int i = 0; i < 20 && !dev_valid; i++) @(negedge clk);
    if (!dev_valid) return;
    seen = 1;
    got = dev_data;
    repeat (dly) @(negedge clk);
    dev_ready = 1'b1;
    @(negedge clk);
    dev_ready = 1'b0;
  endtask

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v, s, c;
    int seen, cnt, rq;

    // R1 reset state
    repeat (3) @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk(v, 8'h00, "R1 register reset");
    end
    chk({7'b0, dev_valid}, 8'h00, "R1 strobe reset");
    chk({7'b0, rd_req}, 8'h00, "R1 read request reset");
    rst_n = 1'b1;
    @(negedge clk);

    // table of writes: R4, R8 boundary, R10, R11
    foreach (VECS[k]) begin
      if (VECS[k].order) begin
        host_wr(2'd3, VECS[k].both ? 8'h05 : 8'h01);
        host_wr(2'd1, VECS[k].data);
      end else begin
        host_wr(2'd1, VECS[k].data);
      end
      rq = 0;
      fork
        host_wr(2'd3, VECS[k].both ? 8'h07 : 8'h03);
        begin
          for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (rd_req) rq = 1;
          end
        end
      join_any
      sink(int'(VECS[k].delay), v, seen);
      chk(8'(seen), 8'd1, "R4 strobe seen");
      chk(v, VECS[k].data, "R11 byte on output");
      wait_idle();
      disable fork;
      chk(8'(rq), 8'd0, "R10 no read request");
      rd(2'd2, s);
      chk(s, 8'h00, "R8 status after write");
    end

    // R6 illegal command, then R5 clear order
    host_wr(2'd3, 8'h02);
    wait_idle();
    rd(2'd2, s);
    chk(s, 8'h02, "R6 error after illegal command");
    rd(2'd3, c);
    chk(c, 8'h00, "R6 command-ready cleared");
    chk(8'(dev_valid), 8'd0, "R6 no strobe");

    host_wr(2'd1, 8'h5A);
    host_wr(2'd3, 8'h03);
    for (int i = 0; i < 20 && !dev_valid; i++) @(negedge clk);
    dev_ready = 1'b1;
    @(negedge clk);
    dev_ready = 1'b0;
    rd(2'd2, s); rd(2'd3, c);
    chk({s[1:0], c[1]}, 3'b011, "R5 error cleared first");
    @(negedge clk);
    rd(2'd2, s); rd(2'd3, c);
    chk({s[1:0], c[1]}, 3'b010, "R5 command-ready cleared second");
    @(negedge clk);
    rd(2'd2, s); rd(2'd3, c);
    chk({s[1:0], c[1]}, 3'b000, "R5 busy cleared last");

    // R3 busy timing
    host_wr(2'd3, 8'h03);
    rd(2'd2, s);
    chk(s[0], 1'b0, "R3 busy not yet set");
    @(negedge clk);
    rd(2'd2, s);
    chk(s[0], 1'b1, "R3 busy set");
    // R7 writes while busy
    host_wr(2'd1, 8'hEE);
    host_wr(2'd3, 8'h00);
    rd(2'd1, v);
    chk(v, 8'h5A, "R7 transmit byte kept");
    rd(2'd3, c);
    chk(c, 8'h03, "R7 command kept");
    rd(2'd2, s);
    chk(s, 8'h01, "R7 status readable while busy");
    chk(dev_data, 8'h5A, "R7 output byte kept");
    dev_ready = 1'b1;
    @(negedge clk);
    dev_ready = 1'b0;
    wait_idle();

    // R8 timeout
    host_wr(2'd3, 8'h03);
    for (int i = 0; i < 20 && !dev_valid; i++) @(negedge clk);
    cnt = 0;
    while (dev_valid && cnt < 400) begin
      cnt++;
      @(negedge clk);
    end
    chk(8'(cnt), 8'(TIMEOUT), "R8 strobe length at timeout");
    wait_idle();
    rd(2'd2, s);
    chk(s, 8'h02, "R8 error after timeout");

    // R9 read command
    host_wr(2'd3, 8'h06);
    for (int i = 0; i < 20 && !rd_req; i++) @(negedge clk);
    chk(8'(rd_req), 8'd1, "R9 read request raised");
    chk(8'(dev_valid), 8'd0, "R9 no output strobe");
    repeat (4) @(negedge clk);
    chk(8'(rd_req), 8'd1, "R9 request held");
    in_data = 8'hC3; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_data = 8'h00;
    wait_idle();
    rd(2'd0, v);
    chk(v, 8'hC3, "R9 byte captured");
    rd(2'd2, s);
    chk(s, 8'h04, "R9 input-ready set, error cleared");
    host_wr(2'd3, 8'h02);
    @(negedge clk);
    rd(2'd2, s);
    chk(s[2:0], 3'b001, "R9 input-ready cleared at busy");
    wait_idle();
    rd(2'd0, v);
    chk(v, 8'hC3, "R2 received byte kept");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule